// File: doc/BRIEF.md
# Serial Host Register Port

This block is a four-wire serial slave. Through it, a host processor reads and writes a bank of 16-bit registers that sits elsewhere in the chip. The host selects the block with an active-low select line and sends a serial clock in bursts. Data goes in on one line and comes back on another. Internally the block drives a plain parallel register bus: a 12-bit address, 16-bit write data, single-cycle write and read strobes, and a 16-bit read data input that the register bank must return in the same cycle as the read strobe.

An access starts with a 16-bit command word. Its top bit picks read or write, one bit enables automatic address stepping, and the low twelve bits name the register. Data words of 16 bits follow, and the host decides how many by holding the select line low. All serial lines are re-timed into the system clock domain, which must run well above the serial clock. The data output has its own enable signal, so that a pad can float the line whenever the block is not sending read data.

Top module: `serial_reg_port`

## Requirements
- R1: Serial words are taken MSB first, one bit per rising edge of `sclk` while `sel_n` is low. In the command word, bit 15 = 1 means read and 0 means write, bit 12 = 1 enables address stepping, and bits 11:0 give the address. Bits 14:13 have no effect.
- R2: A write command followed by one complete 16-bit word produces exactly one `reg_wr` pulse, with `reg_addr` equal to the command address and `reg_wdata` equal to that word.
- R3: A read command produces one `reg_rd` pulse with `reg_addr` equal to the command address. The returned `reg_rdata` word then appears on `sdo` MSB first, and each bit is updated on a falling `sclk` edge. The first bit follows the first falling edge after the command word.
- R4: With bit 12 clear, any further words after the first data word cause no strobe at all, for both reads and writes.
- R5: With bit 12 set on a write, data word k (counting from 0) is written to the command address plus k.
- R6: With bit 12 set on a read, each completed data word starts a fetch from the next address. Word k therefore returns the contents of the command address plus k, and a burst of n words issues n+1 read strobes.
- R7: Address stepping wraps from 12'hFFF to 12'h000.
- R8: Raising `sel_n` before a word is complete abandons that word, so an unfinished data word writes nothing. The next selection starts again with a command word.
- R9: `sdo_oe` is high only while a read is selected and past its command word. It is low during writes, during the command word, and while `sel_n` is high.
- R10: After reset, `sdo_oe`, `reg_wr` and `reg_rd` are all low.
- R11: `reg_wr` and `reg_rd` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, runs in bursts |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| reg_addr | output | 12 | Register bus address |
| reg_wdata | output | 16 | Register bus write data |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_rdata | input | 16 | Register read data, valid in the cycle of reg_rd |

## Verification
The bench aims at word-boundary cases. One is a select release in the middle of a data word; a design that wrote on a partial word would corrupt a register here. Another is a stepped burst that crosses 12'hFFF; a wider or saturating counter would write past the bank or stall on the last address. Others are extra words sent without stepping, which a careless design would write again, and reserved command bits that are set, which would shift the decoded address if the field boundaries were wrong. Read bursts check that each word comes from the next address and is already on `sdo` at the first falling edge. An off-by-one in the prefetch would show up as shifted or repeated data.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int WORD_W      = 16;
  localparam int ADDR_W      = 12;
  localparam int CMD_RD_BIT  = WORD_W - 1;
  localparam int CMD_INC_BIT = WORD_W - 4;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_HOLD} phase_t;

  function automatic logic cmd_is_read(input logic [WORD_W-1:0] w);
    return w[CMD_RD_BIT];
  endfunction

  function automatic logic cmd_is_inc(input logic [WORD_W-1:0] w);
    return w[CMD_INC_BIT];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  // modular step, wraps at the top of the address space
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES+1];
  assign chain[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s+1] <= RST;
      else        chain[s+1] <= chain[s];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/srp_rx.sv
module srp_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_done
);
  localparam int CW = $clog2(W);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      word <= '0;
      word_done <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (shift_en) begin
        word <= {word[W-2:0], din};
        if (cnt == CW'(W-1)) begin
          cnt <= '0;
          word_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // a completed word is always the result of a sampled clock edge
  assert_done_after_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(shift_en));
endmodule

// File: rtl/srp_tx.sv
module srp_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         shift_en,
  output logic         bit_o
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      bit_o <= 1'b0;
    end else if (clear) begin
      bit_o <= 1'b0;
    end else if (load) begin
      sreg <= ld_data;
    end else if (shift_en) begin
      bit_o <= sreg[W-1];
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end

  // the output bit only moves on a falling serial edge
  assert_bit_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bit_o) && !$past(clear)) |-> $past(shift_en));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [WORD_W-1:0] reg_rdata
);
  logic sel_s, sck_s, sdi_s, sck_p;
  logic sel_act, sck_rise, sck_fall;
  logic [WORD_W-1:0] word;
  logic word_done;

  phase_t phase;
  logic rw_q, inc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic wr_q, rd_q;

  srp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sel_n, sclk, sdi}), .q({sel_s, sck_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_p <= 1'b0;
    else        sck_p <= sck_s;
  end

  assign sel_act  = ~sel_s;
  assign sck_rise = sel_act & sck_s & ~sck_p;
  assign sck_fall = sel_act & ~sck_s & sck_p;

  srp_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(~sel_act), .shift_en(sck_rise),
    .din(sdi_s), .word(word), .word_done(word_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      rw_q <= 1'b0;
      inc_q <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (!sel_act) begin
        phase <= PH_CMD;
      end else begin
        if (wr_q && inc_q) addr_q <= addr_next(addr_q);
        if (word_done) begin
          case (phase)
            PH_CMD: begin
              rw_q   <= cmd_is_read(word);
              inc_q  <= cmd_is_inc(word);
              addr_q <= cmd_addr(word);
              rd_q   <= cmd_is_read(word);
              phase  <= PH_DATA;
            end
            PH_DATA: begin
              if (rw_q) begin
                if (inc_q) begin
                  addr_q <= addr_next(addr_q);
                  rd_q <= 1'b1;
                end else begin
                  phase <= PH_HOLD;
                end
              end else begin
                wr_q <= 1'b1;
                wdata_q <= word;
                if (!inc_q) phase <= PH_HOLD;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  srp_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(~sel_act), .load(rd_q),
    .ld_data(reg_rdata), .shift_en(sck_fall), .bit_o(sdo)
  );

  assign sdo_oe    = sel_act & rw_q & (phase != PH_CMD);
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_wr_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(word_done));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_act && $past(!sel_act)) |-> (!reg_wr && !reg_rd));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && inc_q && sel_act) |=> (reg_addr == addr_next($past(reg_addr))));
endmodule

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] wbuf [8];
  logic [27:0] exp_wr [$];
  logic [11:0] exp_rd [$];

  always #5 clk = ~clk;

  function automatic logic [15:0] pat(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h5A3C;
  endfunction

  assign reg_rdata = pat(reg_addr);

  serial_reg_port u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock model comparison of bus strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_wr && reg_rd) chk(1'b0, "R11 both strobes", 32'd1, 32'd0);
      if (reg_wr) begin
        if (exp_wr.size() == 0) chk(1'b0, "R4/R8 unexpected write", {reg_addr, reg_wdata}, 32'd0);
        else begin
          logic [27:0] e;
          e = exp_wr.pop_front();
          chk({reg_addr, reg_wdata} == e, "R2/R5 write addr+data", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_rd) begin
        if (exp_rd.size() == 0) chk(1'b0, "R4 unexpected read", reg_addr, 32'd0);
        else begin
          logic [11:0] e;
          e = exp_rd.pop_front();
          chk(reg_addr == e, "R3/R6 read addr", reg_addr, e);
        end
      end
    end
  end

  task automatic xfer(input logic [15:0] cmd, input int nw, input int stop_bits, input string tag);
    int total;
    bit is_rd, inc;
    logic [11:0] a;
    logic [15:0] word_in;
    int oe_err;
    total = 16 + 16 * nw;
    if (stop_bits >= 0 && stop_bits < total) total = stop_bits;
    is_rd = cmd[15];
    inc = cmd[12];
    a = cmd[11:0];
    word_in = '0;
    oe_err = 0;
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      int w, pos;
      w = b / 16 - 1;
      pos = 15 - (b % 16);
      sclk = 1'b0;
      sdi = (w < 0) ? cmd[pos] : wbuf[w][pos];
      repeat (HALF) @(negedge clk);
      if (sdo_oe != (is_rd && w >= 0)) oe_err++;
      if (w >= 0) word_in[pos] = sdo;
      sclk = 1'b1;
      if (pos == 0) begin
        if (w < 0) begin
          if (is_rd) exp_rd.push_back(a);
        end else if (is_rd) begin
          if (w == 0 || inc) chk(word_in == pat(a), {tag, " R3/R6 read word"}, word_in, pat(a));
          if (inc) begin
            a = a + 1'b1;
            exp_rd.push_back(a);
          end
        end else if (w == 0 || inc) begin
          exp_wr.push_back({a, wbuf[w]});
          if (inc) a = a + 1'b1;
        end
      end
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(oe_err == 0, {tag, " R9 sdo_oe during access"}, oe_err, 0);
    chk(sdo_oe == 1'b0, {tag, " R9 sdo_oe after deselect"}, sdo_oe, 0);
    chk(exp_wr.size() == 0, {tag, " missing writes"}, exp_wr.size(), 0);
    chk(exp_rd.size() == 0, {tag, " missing reads"}, exp_rd.size(), 0);
    exp_wr.delete();
    exp_rd.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R10 reset state",
        {sdo_oe, reg_wr, reg_rd}, 0);

    wbuf[0] = 16'hBEEF;
    xfer(16'h0123, 1, -1, "R2 single write");
    xfer(16'h8045, 1, -1, "R3 single read");
    wbuf[0] = 16'h1357;
    xfer(16'h60AB, 1, -1, "R1 reserved bits");
    wbuf[0] = 16'hAAAA; wbuf[1] = 16'h5555; wbuf[2] = 16'h0F0F;
    xfer(16'h0300, 3, -1, "R4 no-step write");
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333; wbuf[3] = 16'h4444;
    xfer(16'h17FE, 4, -1, "R5 write burst");
    xfer(16'h1FFE, 3, -1, "R7 write wrap");
    xfer(16'h9200, 3, -1, "R6 read burst");
    xfer(16'h9FFF, 2, -1, "R7 read wrap");
    xfer(16'h8777, 2, -1, "R4 no-step read");
    xfer(16'h0456, 1, 7, "R8 abort in command");
    wbuf[0] = 16'hC0DE;
    xfer(16'h0456, 1, -1, "R8 fresh after abort");
    xfer(16'h0457, 1, 25, "R8 abort in data");
    wbuf[0] = 16'hFACE; wbuf[1] = 16'hDEAD;
    xfer(16'h1500, 2, 37, "R8 abort in burst");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule